// File: doc/BRIEF.md
# Character Cell Pixel Row Generator

This block turns one character cell into one 8-pixel slice of a text or graphics display line. Each clock it can accept a character byte, an attribute byte, the 4-bit scan row inside the cell, the running frame counter and a flag that marks the cursor position. It returns an 8-bit pixel row one cycle later. The most significant bit of that row is the leftmost pixel.

The two low attribute bits pick where the base pattern comes from. Mode 0 is coarse 2x4 block graphics. Mode 1 passes the character byte through bit-reversed, as external pixel data. Mode 2 is a blank thin-graphics placeholder. Mode 3 is alphanumeric text read from an internal 128-glyph by 16-row pattern ROM.

After the base pattern is chosen, decorations and overrides are applied in a fixed order: underline, strike-through, flash, blank, cursor, reverse video. Because cursor and reverse video come after blank, they can light a blanked cell again. The display controller upstream advances the frame counter once per rendered scan row. Bits of that counter set the flash and cursor blink phases.

Top module: `char_row_gen`

## Requirements
- R1: `out_valid` equals `in_valid` of the previous clock. `pixels` is 8'h00 whenever `out_valid` is low. Both are low after reset.
- R2: Mode 0 (`attr[1:0]`=0) selects a bit pair from the character by row:
  - rows 0-2 use bits 7 and 3;
  - rows 3-5 use bits 6 and 2;
  - rows 6-8 use bits 5 and 1;
  - rows 9-15 use bits 4 and 0.
  The first bit of the pair lights 8'hF8 and the second lights 8'h07.
- R3: Mode 1 (`attr[1:0]`=1) outputs the character byte with bit 0 and bit 7 exchanged, bit 1 and bit 6 exchanged, and so on (full bit reversal).
- R4: Mode 2 (`attr[1:0]`=2) outputs 8'h00 as its base pattern.
- R5: Mode 3 (`attr[1:0]`=3) reads the pattern ROM at address {char[6:0], row[3:0]}, so character bit 7 has no effect. The ROM byte at character c and row r is ({c[6:0],1'b0}) XOR {r,r}.
- R6: Underline: with `attr[3]` set, row 11 is forced to 8'hFF.
- R7: Strike-through: with `attr[2]` set, rows 5 and 6 are forced to 8'hFF.
- R8: Flash: with `attr[6]` set, the row is forced to 8'h00 while frame counter bit 13 is 1.
- R9: Blank: with `attr[5]` set, the row is forced to 8'h00.
- R10: Cursor: when `cursor_hit` is 1 and frame counter bit 14 is 1, the row is inverted after the blank step.
- R11: Reverse video: with `attr[4]` set, the result of all earlier steps is inverted last. The order of the overrides is underline, strike, flash, blank, cursor, reverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Character cell presented this cycle |
| char_code | input | 8 | Character or graphics byte |
| attr | input | 8 | Attribute byte (mode, decorations, overrides) |
| scan_row | input | 4 | Scan row within the cell |
| frame_cnt | input | FRAME_W | Frame/scan-row counter driving flash and cursor phase |
| cursor_hit | input | 1 | Cell is at the cursor position |
| out_valid | output | 1 | Pixel row valid |
| pixels | output | 8 | Pixel row, MSB leftmost |

## Verification
Every result of this block is due exactly one clock after the edge that captures its inputs. That single stage covers the synchronous ROM read and the override chain behind it; no input reaches the output by any other path. The bench drives a cell on a falling edge. On the next falling edge it compares `out_valid` and `pixels` with the value that the reference model computed for the cell captured one rising edge earlier. A check runs on every clock, so a late or early result shows up as a mismatch. Directed cells cover each mode, each row group, the decoration rows, and the override orderings where cursor or reverse re-light a blanked cell. Randomized cells follow.

// File: rtl/char_row_gen.sv
`timescale 1ns/1ps
module char_row_gen #(
  parameter int FRAME_W    = 16,
  parameter int FLASH_BIT  = 13,
  parameter int CURSOR_BIT = 14,
  parameter int ULINE_ROW  = 11,
  parameter int STRIKE_ROW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         char_code,
  input  logic [7:0]         attr,
  input  logic [3:0]         scan_row,
  input  logic [FRAME_W-1:0] frame_cnt,
  input  logic               cursor_hit,
  output logic               out_valid,
  output logic [7:0]         pixels
);
  localparam int ROM_AW = 11;

  function automatic logic [7:0] rom_word(input logic [ROM_AW-1:0] a);
    return {a[10:4], 1'b0} ^ {a[3:0], a[3:0]};
  endfunction

  logic       v_q, flash_q, blink_q, cur_q;
  logic [7:0] c_q, a_q, glyph_q;
  logic [3:0] r_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      c_q     <= '0;
      a_q     <= '0;
      r_q     <= '0;
      flash_q <= 1'b0;
      blink_q <= 1'b0;
      cur_q   <= 1'b0;
      glyph_q <= '0;
    end else begin
      v_q     <= in_valid;
      c_q     <= char_code;
      a_q     <= attr;
      r_q     <= scan_row;
      flash_q <= frame_cnt[FLASH_BIT];
      blink_q <= frame_cnt[CURSOR_BIT];
      cur_q   <= cursor_hit;
      glyph_q <= rom_word({char_code[6:0], scan_row});
    end
  end

  logic       blk_l, blk_r;
  logic [7:0] blk_row, rev_row, base_row;
  logic [7:0] s_ul, s_st, s_fl, s_bl, s_cu;

  always_comb begin
    case (r_q)
      4'd0, 4'd1, 4'd2: begin blk_l = c_q[7]; blk_r = c_q[3]; end
      4'd3, 4'd4, 4'd5: begin blk_l = c_q[6]; blk_r = c_q[2]; end
      4'd6, 4'd7, 4'd8: begin blk_l = c_q[5]; blk_r = c_q[1]; end
      default:          begin blk_l = c_q[4]; blk_r = c_q[0]; end
    endcase
  end

  assign blk_row = {{5{blk_l}}, {3{blk_r}}};

  for (genvar i = 0; i < 8; i++) begin : g_rev
    assign rev_row[i] = c_q[7-i];
  end

  always_comb begin
    case (a_q[1:0])
      2'd0:    base_row = blk_row;
      2'd1:    base_row = rev_row;
      2'd2:    base_row = 8'h00;
      default: base_row = glyph_q;
    endcase
  end

  assign s_ul = (a_q[3] && r_q == 4'(ULINE_ROW)) ? 8'hFF : base_row;
  assign s_st = (a_q[2] && (r_q == 4'(STRIKE_ROW) || r_q == 4'(STRIKE_ROW + 1))) ? 8'hFF : s_ul;
  assign s_fl = (a_q[6] && flash_q) ? 8'h00 : s_st;
  assign s_bl = a_q[5] ? 8'h00 : s_fl;
  assign s_cu = (cur_q && blink_q) ? ~s_bl : s_bl;

  assign out_valid = v_q;
  assign pixels    = v_q ? (a_q[4] ? ~s_cu : s_cu) : 8'h00;

  a_r1_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (pixels == 8'h00));
  a_r9_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && attr[5] && !attr[4] && !(cursor_hit && frame_cnt[CURSOR_BIT]))
    |=> (pixels == 8'h00));
  a_r6_underline_lit: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && attr[3] && scan_row == 4'(ULINE_ROW) && attr[6:4] == 3'b000 &&
     !(cursor_hit && frame_cnt[CURSOR_BIT])) |=> (pixels == 8'hFF));
  a_r4_thin_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && attr[1:0] == 2'd2 && attr[6:2] == 5'd0 &&
     !(cursor_hit && frame_cnt[CURSOR_BIT])) |=> (pixels == 8'h00));
  a_r11_reverse_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && attr[5] && attr[4] && !(cursor_hit && frame_cnt[CURSOR_BIT]))
    |=> (pixels == 8'hFF));
endmodule

// File: tb/char_row_gen_bench.sv
`timescale 1ns/1ps
module char_row_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  char_code = '0, attr = '0;
  logic [3:0]  scan_row = '0;
  logic [15:0] frame_cnt = '0;
  logic        cursor_hit = 1'b0;
  logic        out_valid;
  logic [7:0]  pixels;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  char_row_gen u_char_row_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .char_code(char_code),
    .attr(attr), .scan_row(scan_row), .frame_cnt(frame_cnt),
    .cursor_hit(cursor_hit), .out_valid(out_valid), .pixels(pixels));

  function automatic logic [7:0] model(input logic [7:0] c, input logic [7:0] a,
                                       input int r, input logic [15:0] f, input logic cu);
    logic [7:0] p;
    int grp;
    p = 8'h00;
    if (a[1:0] == 2'd0) begin
      grp = (r < 9) ? r / 3 : 3;
      if (c[7-grp]) p = p | 8'hF8;
      if (c[3-grp]) p = p | 8'h07;
    end else if (a[1:0] == 2'd1) begin
      for (int i = 0; i < 8; i++) p[i] = c[7-i];
    end else if (a[1:0] == 2'd3) begin
      p = {c[6:0], 1'b0} ^ {r[3:0], r[3:0]};
    end
    if (a[3] && r == 11) p = 8'hFF;
    if (a[2] && (r == 5 || r == 6)) p = 8'hFF;
    if (a[6] && f[13]) p = 8'h00;
    if (a[5]) p = 8'h00;
    if (cu && f[14]) p = ~p;
    if (a[4]) p = ~p;
    return p;
  endfunction

  logic       exp_v = 1'b0;
  logic [7:0] exp_p = '0;
  string      exp_tag = "R1";

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [7:0] c, input logic [7:0] a,
                      input int r, input logic [15:0] f, input logic cu);
    @(negedge clk);
    check({exp_tag, " valid"}, {7'd0, out_valid}, {7'd0, exp_v});
    check({exp_tag, " pixels"}, pixels, exp_v ? exp_p : 8'h00);
    in_valid = v; char_code = c; attr = a; scan_row = 4'(r);
    frame_cnt = f; cursor_hit = cu;
    exp_v = v; exp_p = model(c, a, r, f, cu); exp_tag = tag;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {7'd0, out_valid}, 8'h00);
    check("R1 reset pixels", pixels, 8'h00);
    rst_n = 1'b1;
    step("R1", 1'b0, 8'hFF, 8'h03, 0, 16'h0, 1'b0);
    for (int r = 0; r < 16; r++) step("R2", 1'b1, 8'hA5, 8'h00, r, 16'h0, 1'b0);
    for (int r = 0; r < 16; r++) step("R2", 1'b1, 8'h5A, 8'h00, r, 16'h0, 1'b0);
    step("R2", 1'b1, 8'h88, 8'h00, 1, 16'h0, 1'b0);
    step("R2", 1'b1, 8'h11, 8'h00, 15, 16'h0, 1'b0);
    step("R3", 1'b1, 8'h01, 8'h01, 0, 16'h0, 1'b0);
    step("R3", 1'b1, 8'hC4, 8'h01, 7, 16'h0, 1'b0);
    step("R4", 1'b1, 8'hFF, 8'h02, 3, 16'h0, 1'b0);
    step("R5", 1'b1, 8'h41, 8'h03, 2, 16'h0, 1'b0);
    step("R5", 1'b1, 8'hC1, 8'h03, 2, 16'h0, 1'b0);
    step("R5", 1'b1, 8'h7F, 8'h03, 15, 16'h0, 1'b0);
    step("R1", 1'b0, 8'h7F, 8'h03, 15, 16'h0, 1'b0);
    step("R6", 1'b1, 8'h00, 8'h0A, 11, 16'h0, 1'b0);
    step("R6", 1'b1, 8'h00, 8'h0A, 10, 16'h0, 1'b0);
    step("R7", 1'b1, 8'h00, 8'h06, 5, 16'h0, 1'b0);
    step("R7", 1'b1, 8'h00, 8'h06, 6, 16'h0, 1'b0);
    step("R7", 1'b1, 8'h00, 8'h06, 7, 16'h0, 1'b0);
    step("R8", 1'b1, 8'h41, 8'h43, 3, 16'h2000, 1'b0);
    step("R8", 1'b1, 8'h41, 8'h43, 3, 16'h0000, 1'b0);
    step("R9", 1'b1, 8'h41, 8'h2B, 11, 16'h0, 1'b0);
    step("R10", 1'b1, 8'h41, 8'h03, 4, 16'h4000, 1'b1);
    step("R10", 1'b1, 8'h41, 8'h03, 4, 16'h4000, 1'b0);
    step("R10", 1'b1, 8'h41, 8'h03, 4, 16'h0000, 1'b1);
    step("R10", 1'b1, 8'h41, 8'h23, 4, 16'h4000, 1'b1);
    step("R11", 1'b1, 8'h41, 8'h13, 4, 16'h0, 1'b0);
    step("R11", 1'b1, 8'h41, 8'h33, 4, 16'h0, 1'b0);
    step("R11", 1'b1, 8'h41, 8'h13, 4, 16'h4000, 1'b1);
    step("R11", 1'b1, 8'h00, 8'h5E, 11, 16'h6000, 1'b1);
    for (int n = 0; n < 600; n++)
      step("R11", 1'($urandom_range(0, 3) != 0), 8'($urandom), 8'($urandom),
           int'($urandom_range(0, 15)), 16'($urandom), 1'($urandom));
    step("R1", 1'b0, 8'h00, 8'h00, 0, 16'h0, 1'b0);
    step("R1", 1'b0, 8'h00, 8'h00, 0, 16'h0, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule